// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block watches sixteen asynchronous interrupt pins. Each pin is brought into the clock domain, and an event is detected on it according to a trigger type taken from a shared configuration word. Detected events set a per-line pending flag. Software clears a flag by writing a one to it. A per-line mask keeps a pending line away from the outputs but does not stop the flag from being set. Unmasked pending lines are merged into three grouped interrupt requests for a parent interrupt controller. Line groups are of unequal size: the lowest four lines, the middle eight and the top four.

Each line has a two-state pending machine. The states are `LN_IDLE` (no event stored) and `LN_PEND` (event stored). There are two transitions. *capture* goes from `LN_IDLE` to `LN_PEND` when the detector reports an event. *release* goes from `LN_PEND` to `LN_IDLE` on an acknowledge, but only if no event is reported in the same cycle. In every other case the state holds.

Software reaches the block through a single-cycle write strobe with byte address and write data, and a combinational read of the addressed register. The block has three registers. Trigger configuration is at offset 0x0. The line mask is at offset 0x4, bit n for line n. Pending is at offset 0x8, bit n for line n, and a write of one clears the bit.

Top module: `ext_irq_grouper`

## Requirements
- R1: During and straight after reset, configuration reads 0, mask reads 0xFFFF, pending reads 0 and all three group outputs are 0.
- R2: Trigger code 3'b100 sets the pending bit on a 0-to-1 change of the pin and not on a 1-to-0 change.
- R3: Trigger code 3'b010 sets the pending bit on a 1-to-0 change of the pin and not on a 0-to-1 change.
- R4: Trigger code 3'b110 sets the pending bit on either change of the pin.
- R5: Code 3'b001 (high level) and code 3'b000 (low level) set the pending bit on every clock while the level is active. An acknowledge leaves the bit set until the pin leaves the active level.
- R6: Codes 3'b011, 3'b101 and 3'b111 never set a pending bit.
- R7: Lines 2k and 2k+1 both take their trigger code from configuration bits [4k+2:4k]. Bit 4k+3 has no effect on detection.
- R8: A line drives its group output only while its pending bit is 1 and its mask bit is 0. A pending bit latches even while the line is masked, and clearing the mask bit raises the group output at once.
- R9: Writing the pending register clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R10: If an event is detected in the same cycle as an acknowledge of that line, the pending bit stays set.
- R11: Output bit 0 is the OR over lines 0-3, bit 1 over lines 4-11 and bit 2 over lines 12-15, each using unmasked pending lines only.
- R12: Configuration is at 0x0 (all 32 bits read back), mask at 0x4 (bits 15:0) and pending at 0x8 (bits 15:0). All other read bits and other offsets read 0, and writes to other offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 16 | Asynchronous external interrupt pins |
| wr_en | input | 1 | Single-cycle register write strobe |
| addr | input | 4 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register (combinational) |
| grp_irq | output | 3 | Grouped interrupt requests to the parent controller |

## Verification
Two things can happen to the same pending bit in one cycle: a detected event (*capture*) and a software acknowledge (*release*). The bench first sets a line's pending bit through a rising edge and lowers the pin. It then raises the pin again and times the acknowledge write so that the write lands on the clock edge where the synchronized edge is reported. It judges the result by reading the pending register back afterwards, which must still show the bit set. Level-triggered lines show the same collision on every cycle: an acknowledge given while the level is held must not clear the bit, and the bench checks this both in directed tests and in random rounds.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    localparam int unsigned NLINES    = 16;
    localparam int unsigned NGROUPS   = 3;
    localparam int unsigned CODE_W    = 3;
    localparam int unsigned FIELD_STR = 4;
    localparam int unsigned AW        = 4;
    localparam int unsigned DW        = 32;

    localparam logic [AW-1:0] OFF_CFG  = 4'h0;
    localparam logic [AW-1:0] OFF_MASK = 4'h4;
    localparam logic [AW-1:0] OFF_PEND = 4'h8;

    typedef enum logic [CODE_W-1:0] {
        TRG_LOW  = 3'b000,
        TRG_HIGH = 3'b001,
        TRG_FALL = 3'b010,
        TRG_RISE = 3'b100,
        TRG_BOTH = 3'b110
    } trig_e;

    typedef enum logic {
        LN_IDLE = 1'b0,
        LN_PEND = 1'b1
    } line_state_e;

    // Inclusive lower/upper line index of each output group.
    function automatic int unsigned grp_lo(input int unsigned g);
        case (g)
            0:       grp_lo = 0;
            1:       grp_lo = 4;
            default: grp_lo = 12;
        endcase
    endfunction

    function automatic int unsigned grp_hi(input int unsigned g);
        case (g)
            0:       grp_hi = 3;
            1:       grp_hi = 11;
            default: grp_hi = 15;
        endcase
    endfunction

    function automatic logic [NLINES-1:0] grp_sel(input int unsigned g);
        logic [NLINES-1:0] v;
        v = '0;
        for (int unsigned i = 0; i < NLINES; i++) begin
            if (i >= grp_lo(g) && i <= grp_hi(g)) v[i] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/eirq_line.sv
module eirq_line
    import eirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              ack_i,
    output logic              evt_o,
    output logic              pend_o
);

    logic        prev_q;
    line_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_i;
    end

    // Event decode from the trigger code of this line's pair.
    always_comb begin
        unique case (code_i)
            TRG_LOW:  evt_o = !sync_i;
            TRG_HIGH: evt_o = sync_i;
            TRG_FALL: evt_o = prev_q && !sync_i;
            TRG_RISE: evt_o = !prev_q && sync_i;
            TRG_BOTH: evt_o = prev_q ^ sync_i;
            default:  evt_o = 1'b0;
        endcase
    end

    // Pending machine: state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_IDLE;
        else        state_q <= state_d;
    end

    // Pending machine: capture / release transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_IDLE: if (evt_o)            state_d = LN_PEND;
            LN_PEND: if (ack_i && !evt_o)  state_d = LN_IDLE;
            default:                       state_d = LN_IDLE;
        endcase
    end

    // Pending machine: outputs.
    always_comb begin
        unique case (state_q)
            LN_PEND: pend_o = 1'b1;
            default: pend_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/ext_irq_grouper.sv
module ext_irq_grouper
    import eirq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NLINES-1:0]    pin_i,
    input  logic                 wr_en,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    output logic [NGROUPS-1:0]   grp_irq
);

    logic [NLINES-1:0] sync_w;
    logic [NLINES-1:0] evt_w;
    logic [NLINES-1:0] pend_q;
    logic [NLINES-1:0] mask_q;
    logic [NLINES-1:0] ack_w;
    logic [DW-1:0]     cfg_q;
    logic [NLINES-1:0] live_w;

    eirq_sync #(.WIDTH(NLINES), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (sync_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            mask_q <= '1;
        end else if (wr_en) begin
            if (addr == OFF_CFG)  cfg_q  <= wdata;
            if (addr == OFF_MASK) mask_q <= wdata[NLINES-1:0];
        end
    end

    assign ack_w = (wr_en && addr == OFF_PEND) ? wdata[NLINES-1:0] : '0;

    generate
        for (genvar i = 0; i < NLINES; i++) begin : g_line
            localparam int unsigned SHIFT = (i / 2) * FIELD_STR;
            eirq_line u_line (
                .clk    (clk),
                .rst_n  (rst_n),
                .sync_i (sync_w[i]),
                .code_i (cfg_q[SHIFT +: CODE_W]),
                .ack_i  (ack_w[i]),
                .evt_o  (evt_w[i]),
                .pend_o (pend_q[i])
            );
        end
    endgenerate

    assign live_w = pend_q & ~mask_q;

    generate
        for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
            localparam logic [NLINES-1:0] SEL = grp_sel(g);
            assign grp_irq[g] = |(live_w & SEL);
        end
    endgenerate

    always_comb begin
        rdata = '0;
        case (addr)
            OFF_CFG:  rdata = cfg_q;
            OFF_MASK: rdata[NLINES-1:0] = mask_q;
            OFF_PEND: rdata[NLINES-1:0] = pend_q;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/eirq_checker.sv
module eirq_checker
    import eirq_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [AW-1:0]       addr,
    input logic [DW-1:0]       wdata,
    input logic [NLINES-1:0]   pend,
    input logic [NLINES-1:0]   mask,
    input logic [NLINES-1:0]   evt,
    input logic [NGROUPS-1:0]  grp
);

    // R1: outputs quiet while reset is held
    always @(negedge clk) begin
        if (!rst_n) a_r1_reset_quiet: assert (grp == '0 && pend == '0);
    end

    // R9: acknowledged bits without a concurrent event are clear next cycle
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_PEND) |=> ((pend & $past(wdata[NLINES-1:0] & ~evt)) == '0));

    // R9: bits written as zero keep their value
    a_r9_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_PEND) |=> (($past(pend & ~wdata[NLINES-1:0]) & ~pend) == '0));

    // R10: a detected event always leaves the bit set
    a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((pend & $past(evt)) == $past(evt)));

    // R2: a pending bit never rises without a detected event
    a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & ~$past(pend) & ~$past(evt)) == '0));

    // R8: a fully masked controller raises no group request
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1) |-> (grp == '0));

    // R11: no group request without some unmasked pending line
    a_r11_grp_source: assert property (@(posedge clk) disable iff (!rst_n)
        (grp != '0) |-> ((pend & ~mask) != '0));

    // R12: mask write lands in the mask register
    a_r12_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_MASK) |=> (mask == $past(wdata[NLINES-1:0])));

endmodule

bind ext_irq_grouper eirq_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .pend  (pend_q),
    .mask  (mask_q),
    .evt   (evt_w),
    .grp   (grp_irq)
);

// File: tb/ext_irq_grouper_bench.sv
module ext_irq_grouper_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pin_i = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  grp_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] m_cfg  = '0;
    logic [15:0] m_mask = '1;
    logic [15:0] m_pend = '0;
    logic [15:0] m_pins = '0;

    ext_irq_grouper u_ext_irq_grouper (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .grp_irq(grp_irq)
    );

    always #5 clk = ~clk;

    function automatic logic [2:0] code_of(input logic [31:0] c, input int ln);
        return c[(ln/2)*4 +: 3];
    endfunction

    function automatic logic [15:0] level_on(input logic [31:0] c, input logic [15:0] p);
        logic [15:0] v = '0;
        for (int i = 0; i < 16; i++) begin
            if (code_of(c, i) == 3'b000 && !p[i]) v[i] = 1'b1;
            if (code_of(c, i) == 3'b001 &&  p[i]) v[i] = 1'b1;
        end
        return v;
    endfunction

    function automatic logic [15:0] edge_on(input logic [31:0] c, input logic [15:0] o, input logic [15:0] n);
        logic [15:0] v = '0;
        for (int i = 0; i < 16; i++) begin
            logic [2:0] k = code_of(c, i);
            if (k == 3'b100 && !o[i] &&  n[i]) v[i] = 1'b1;
            if (k == 3'b010 &&  o[i] && !n[i]) v[i] = 1'b1;
            if (k == 3'b110 && (o[i] ^ n[i]))  v[i] = 1'b1;
        end
        return v;
    endfunction

    function automatic logic [2:0] grp_exp(input logic [15:0] p, input logic [15:0] m);
        logic [15:0] v = p & ~m;
        return {|v[15:12], |v[11:4], |v[3:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [31:0] c);
        wr(4'h0, c); m_cfg = c;
        settle();
        m_pend |= level_on(m_cfg, m_pins);
    endtask

    task automatic set_mask(input logic [15:0] m);
        wr(4'h4, {16'h0, m}); m_mask = m;
    endtask

    task automatic ack(input logic [15:0] a);
        wr(4'h8, {16'h0, a});
        settle();
        m_pend = (m_pend & ~a) | level_on(m_cfg, m_pins);
    endtask

    task automatic pins(input logic [15:0] n);
        @(negedge clk);
        pin_i = n;
        repeat (5) @(negedge clk);
        m_pend |= edge_on(m_cfg, m_pins, n) | level_on(m_cfg, n);
        m_pins = n;
    endtask

    task automatic check_state(input string tag);
        logic [31:0] d;
        rd(4'h8, d);
        chk({tag, " pend"}, d, {16'h0, m_pend});
        chk({tag, " grp R11"}, {29'h0, grp_irq}, {29'h0, grp_exp(m_pend, m_mask)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5eed_1234));
        // R1 reset values
        repeat (3) @(negedge clk);
        addr = 4'h0; #1 chk("R1 cfg", rdata, 32'h0);
        addr = 4'h4; #1 chk("R1 mask", rdata, 32'h0000ffff);
        addr = 4'h8; #1 chk("R1 pend", rdata, 32'h0);
        chk("R1 grp", {29'h0, grp_irq}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 grp after release", {29'h0, grp_irq}, 32'h0);
        settle();
        m_pend = level_on(32'h0, 16'h0);

        // disable all lines, clear (R6)
        set_cfg(32'h7777_7777);
        ack(16'hffff);
        set_mask(16'h0000);
        pins(16'hffff); pins(16'h0000);
        check_state("R6 disabled 111");
        set_cfg(32'h5555_5555);
        pins(16'hffff); pins(16'h0000);
        check_state("R6 disabled 101");
        set_cfg(32'h3333_3333);
        pins(16'hffff); pins(16'h0000);
        check_state("R6 disabled 011");

        // R2 rising on pair 0
        set_cfg(32'h3333_3334);
        pins(16'h0001);
        rd(4'h8, d); chk("R2 rise sets", d, 32'h1);
        ack(16'hffff);
        pins(16'h0000);
        rd(4'h8, d); chk("R2 fall ignored", d, 32'h0);

        // R3 falling on pair 1
        set_cfg(32'h3333_3323);
        pins(16'h0004);
        rd(4'h8, d); chk("R3 rise ignored", d, 32'h0);
        pins(16'h0000);
        rd(4'h8, d); chk("R3 fall sets", d, 32'h4);
        ack(16'hffff);

        // R4 both on pair 7
        set_cfg(32'h6333_3333);
        pins(16'h8000);
        rd(4'h8, d); chk("R4 rise sets", d, 32'h8000);
        ack(16'hffff);
        pins(16'h0000);
        rd(4'h8, d); chk("R4 fall sets", d, 32'h8000);
        ack(16'hffff);

        // R5 high level: ack ineffective while held
        set_cfg(32'h3333_3313);
        pins(16'h0008);
        ack(16'h0008);
        rd(4'h8, d); chk("R5 high held", d, 32'h8);
        pins(16'h0000);
        ack(16'h0008);
        rd(4'h8, d); chk("R5 high released", d, 32'h0);
        // R5 low level on pair 2
        set_cfg(32'h3333_3033);
        ack(16'h0030);
        rd(4'h8, d); chk("R5 low held", d, 32'h30);
        pins(16'h0030);
        ack(16'h0030);
        rd(4'h8, d); chk("R5 low released", d, 32'h0);

        // R7 pair sharing, bit 3 ignored
        set_cfg(32'h3333_333c);
        pins(16'h0032);
        rd(4'h8, d); chk("R7 odd line shares field", d, 32'h2);
        ack(16'hffff);
        pins(16'h0030);

        // R8 latch while masked, unmask raises
        set_mask(16'hffff);
        pins(16'h0031);
        chk("R8 masked grp", {29'h0, grp_irq}, 32'h0);
        rd(4'h8, d); chk("R8 latched masked", d, 32'h1);
        set_mask(16'hfffe);
        #1 chk("R8 unmask raises", {29'h0, grp_irq}, 32'h1);

        // R9 zero keeps, one clears
        set_cfg(32'h6666_6666);
        set_mask(16'h0000);
        ack(16'hffff);
        pins(16'hf0ff);
        ack(16'h00f0);
        rd(4'h8, d); chk("R9 w1c partial", d, 32'h0fffe & 32'hffff & {16'h0, 16'hf00f} | 32'h0);
        check_state("R9 model");
        ack(16'hffff);

        // R10 event on same cycle as ack
        set_cfg(32'h3333_3334);
        pins(16'h0000);
        ack(16'hffff);
        pins(16'h0001);
        pins(16'h0000);
        @(negedge clk); pin_i = 16'h0001;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'h8; wdata = 32'h1;
        @(negedge clk);
        wr_en = 1'b0;
        settle();
        m_pins = 16'h0001;
        rd(4'h8, d); chk("R10 event beats ack", d, 32'h1);
        ack(16'hffff);

        // R12 map and unmapped offsets
        wr(4'hc, 32'hdead_beef);
        rd(4'hc, d); chk("R12 unmapped reads 0", d, 32'h0);
        rd(4'h0, d); chk("R12 cfg unchanged", d, m_cfg);
        rd(4'h4, d); chk("R12 mask unchanged", d, {16'h0, m_mask});
        wr(4'h0, 32'hbbbb_bbbb); m_cfg = 32'hbbbb_bbbb;
        rd(4'h0, d); chk("R12 cfg full readback", d, 32'hbbbb_bbbb);
        wr(4'h4, 32'hffff_1234); m_mask = 16'h1234;
        rd(4'h4, d); chk("R12 mask upper zero", d, 32'h1234);

        // Random rounds: R2 R3 R4 R5 R8 R9 R11
        for (int r = 0; r < 30; r++) begin
            logic [31:0] c = '0;
            for (int k = 0; k < 8; k++) begin
                logic [2:0] opt[6] = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b110, 3'b011};
                c[k*4 +: 4] = {1'($urandom), opt[$urandom % 6]};
            end
            set_cfg(c);
            set_mask(16'($urandom));
            ack(16'hffff);
            check_state("R5 random level");
            pins(16'($urandom));
            check_state("R2 random edges");
            ack(16'($urandom));
            check_state("R9 random ack");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule